// File: doc/BRIEF.md
# Replay Trace Fault Localiser

This block takes two replays of the same instruction stream in lockstep. One replay comes from a core suspected of a permanent fault. The other comes from a healthy core. Each beat carries one entry from each replay: the destination result plus the decoder, ALU and physical register that the instruction went through. A beat diverges when any of those four fields differ between the two entries.

For each divergent instruction, the block charges one point to every resource the suspect core used for it, that is, the resources named in the faulty entry. It does not trust a single divergence. An instruction can diverge even when it never touched the broken unit, for example when a corrupted rename mapping feeds it bad operands. The block therefore waits for evidence to build up.

The verdict is produced when the caller signals end of trace, or automatically once a set number of divergences has been seen. It names the resource class and index with the most charges, together with that charge count.

Top module: `trace_fault_localizer`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `in_ready` are 0 and the verdict outputs (`v_class`, `v_index`, `v_hits`) are 0.
- R2: A `start` pulse clears every charge counter, the divergence tally and the verdict. From the next cycle on, `in_ready` is 1 and `done` is 0.
- R3: A beat diverges if the two results differ, or if the decoder, ALU or register fields differ. A beat with all four fields equal charges nothing.
- R4: Each divergent beat adds one to the counter of the faulty entry's decoder, ALU and physical register.
- R5: The verdict is the counter with the highest value. The class code is 1 for ALU, 2 for decoder and 3 for physical register. `v_index` is the unit number and `v_hits` is the counter value.
- R6: When counters tie, ALU wins over decoder, decoder wins over register, and within a class the lower index wins.
- R7: If no beat diverged, the verdict is class 0, index 0, hits 0.
- R8: `trace_end` is sampled while `in_ready` is 1. At the edge that samples it, `in_ready` falls. At the following edge, `done` rises for exactly one cycle.
- R9: The beat that carries divergence number DIV_LIMIT ends the run with no `trace_end`. `in_ready` falls at that edge and `done` rises at the next edge. Later beats are not accepted.
- R10: Every charge counter saturates at 255 and does not wrap.
- R11: The verdict is held unchanged after `done` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears all counters and opens a new run |
| in_valid | input | 1 | A paired entry is present |
| in_ready | output | 1 | Block accepts entries (run open) |
| flt_val | input | DW | Result from the faulty replay |
| flt_dec | input | clog2(NDEC) | Decoder used by the faulty replay |
| flt_alu | input | clog2(NALU) | ALU used by the faulty replay |
| flt_preg | input | clog2(NPREG) | Physical register used by the faulty replay |
| ref_val | input | DW | Result from the healthy replay |
| ref_dec | input | clog2(NDEC) | Decoder used by the healthy replay |
| ref_alu | input | clog2(NALU) | ALU used by the healthy replay |
| ref_preg | input | clog2(NPREG) | Physical register used by the healthy replay |
| trace_end | input | 1 | No more entries; produce the verdict |
| done | output | 1 | One-cycle pulse when the verdict is loaded |
| v_class | output | 2 | 0 none, 1 ALU, 2 decoder, 3 register |
| v_index | output | IW | Index of the suspected unit |
| v_hits | output | CW | Counter value of the suspected unit |

## Verification
The tests use a set of distinct patterns:
- A trace with no divergence, which checks the "none" code.
- A classic ALU fault, where divergent instructions share one ALU but use different decoders and registers. This separates ALU attribution from the other classes.
- Divergences caused by mismatched resource fields alone, with equal results. These show that field mismatches count and let a register win.
- Exact ties, both across classes and within one class, which expose the priority order.
- A trace of 300 divergences on one unit, which separates saturation from wrap-around.
- A 1000-divergence run with no end marker, which shows the automatic cutoff and that the next beat is refused.

// File: rtl/trace_fault_localizer.sv
module trace_fault_localizer #(
  parameter int NDEC = 2,
  parameter int NALU = 4,
  parameter int NPREG = 64,
  parameter int DW = 32,
  parameter int CW = 8,
  parameter int DIV_LIMIT = 1000,
  localparam int DECW = $clog2(NDEC),
  localparam int ALUW = $clog2(NALU),
  localparam int PRW = $clog2(NPREG),
  localparam int IW = (PRW > ALUW) ? ((PRW > DECW) ? PRW : DECW) : ((ALUW > DECW) ? ALUW : DECW),
  localparam int DCW = $clog2(DIV_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   flt_val,
  input  logic [DECW-1:0] flt_dec,
  input  logic [ALUW-1:0] flt_alu,
  input  logic [PRW-1:0]  flt_preg,
  input  logic [DW-1:0]   ref_val,
  input  logic [DECW-1:0] ref_dec,
  input  logic [ALUW-1:0] ref_alu,
  input  logic [PRW-1:0]  ref_preg,
  input  logic            trace_end,
  output logic            done,
  output logic [1:0]      v_class,
  output logic [IW-1:0]   v_index,
  output logic [CW-1:0]   v_hits
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_HOLD} st_t;
  st_t state;

  logic [CW-1:0]  alu_cnt [NALU];
  logic [CW-1:0]  dec_cnt [NDEC];
  logic [CW-1:0]  reg_cnt [NPREG];
  logic [DCW-1:0] div_cnt;

  assign in_ready = (state == S_RUN);

  wire fire = in_valid && in_ready;
  wire diverge = (flt_val != ref_val) || (flt_dec != ref_dec) ||
                 (flt_alu != ref_alu) || (flt_preg != ref_preg);
  wire charge = fire && diverge;
  wire at_limit = charge && (div_cnt == DCW'(DIV_LIMIT - 1));

  logic [1:0]    best_cls;
  logic [IW-1:0] best_idx;
  logic [CW-1:0] best_cnt;

  always_comb begin
    best_cls = 2'd0;
    best_idx = '0;
    best_cnt = '0;
    for (int a = 0; a < NALU; a++)
      if (alu_cnt[a] > best_cnt) begin
        best_cnt = alu_cnt[a]; best_cls = 2'd1; best_idx = IW'(a);
      end
    for (int d = 0; d < NDEC; d++)
      if (dec_cnt[d] > best_cnt) begin
        best_cnt = dec_cnt[d]; best_cls = 2'd2; best_idx = IW'(d);
      end
    for (int p = 0; p < NPREG; p++)
      if (reg_cnt[p] > best_cnt) begin
        best_cnt = reg_cnt[p]; best_cls = 2'd3; best_idx = IW'(p);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      div_cnt <= '0;
      done <= 1'b0;
      v_class <= '0;
      v_index <= '0;
      v_hits <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= S_RUN;
        div_cnt <= '0;
        v_class <= '0;
        v_index <= '0;
        v_hits <= '0;
      end else begin
        case (state)
          S_RUN: begin
            if (charge) div_cnt <= div_cnt + 1'b1;
            if (trace_end || at_limit) state <= S_FIN;
          end
          S_FIN: begin
            v_class <= best_cls;
            v_index <= best_idx;
            v_hits <= best_cnt;
            done <= 1'b1;
            state <= S_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar a = 0; a < NALU; a++) begin : g_alu
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) alu_cnt[a] <= '0;
      else if (start) alu_cnt[a] <= '0;
      else if (charge && flt_alu == ALUW'(a) && alu_cnt[a] != '1) alu_cnt[a] <= alu_cnt[a] + 1'b1;
  end

  for (genvar d = 0; d < NDEC; d++) begin : g_dec
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dec_cnt[d] <= '0;
      else if (start) dec_cnt[d] <= '0;
      else if (charge && flt_dec == DECW'(d) && dec_cnt[d] != '1) dec_cnt[d] <= dec_cnt[d] + 1'b1;
  end

  for (genvar p = 0; p < NPREG; p++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) reg_cnt[p] <= '0;
      else if (start) reg_cnt[p] <= '0;
      else if (charge && flt_preg == PRW'(p) && reg_cnt[p] != '1) reg_cnt[p] <= reg_cnt[p] + 1'b1;
  end

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == S_FIN));
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (in_ready && !done && v_hits == '0));
  a_r7_none_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && v_class == 2'd0) |-> (v_index == '0 && v_hits == '0));
  a_r9_limit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= DCW'(DIV_LIMIT));
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alu_cnt[0]) == '1 && !$past(start)) |-> alu_cnt[0] == '1);
  a_r11_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> ($stable(v_class) && $stable(v_index) && $stable(v_hits)));

endmodule

// File: tb/trace_fault_localizer_bench.sv
module trace_fault_localizer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, trace_end = 0;
  logic [31:0] flt_val = 0, ref_val = 0;
  logic [0:0] flt_dec = 0, ref_dec = 0;
  logic [1:0] flt_alu = 0, ref_alu = 0;
  logic [5:0] flt_preg = 0, ref_preg = 0;
  logic in_ready, done;
  logic [1:0] v_class;
  logic [5:0] v_index;
  logic [7:0] v_hits;
  int vectors = 0, fails = 0, accepted = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_fault_localizer u_trace_fault_localizer (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .flt_val(flt_val), .flt_dec(flt_dec), .flt_alu(flt_alu), .flt_preg(flt_preg),
    .ref_val(ref_val), .ref_dec(ref_dec), .ref_alu(ref_alu), .ref_preg(ref_preg),
    .trace_end(trace_end), .done(done), .v_class(v_class), .v_index(v_index), .v_hits(v_hits));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] fv, logic [31:0] rv, logic fd, logic rd,
                      logic [1:0] fa, logic [1:0] ra, logic [5:0] fp, logic [5:0] rp);
    @(negedge clk);
    flt_val = fv; ref_val = rv; flt_dec = fd; ref_dec = rd;
    flt_alu = fa; ref_alu = ra; flt_preg = fp; ref_preg = rp;
    in_valid = 1;
    if (in_ready) accepted++;
    @(posedge clk);
  endtask

  task automatic div(logic d, logic [1:0] a, logic [5:0] p);
    send(32'h1111, 32'h2222, d, d, a, a, p, p);
  endtask

  task automatic same(logic d, logic [1:0] a, logic [5:0] p);
    send(32'h55, 32'h55, d, d, a, a, p, p);
  endtask

  task automatic open_run(string req);
    @(negedge clk); in_valid = 0; start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    chk({req, " ready after start"}, in_ready, 1);
    chk({req, " done after start"}, done, 0);
    chk({req, " verdict cleared"}, v_hits, 0);
    accepted = 0;
  endtask

  task automatic close_run(bit use_end, logic [1:0] cls, logic [5:0] idx, logic [7:0] hits, string req);
    @(negedge clk); in_valid = 0;
    if (use_end) begin
      trace_end = 1;
      @(posedge clk);
      @(negedge clk); trace_end = 0;
    end
    chk({req, " R8 ready low while closing"}, in_ready, 0);
    chk({req, " R8 done not early"}, done, 0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R8 done pulse"}, done, 1);
    chk({req, " class"}, v_class, cls);
    chk({req, " index"}, v_index, idx);
    chk({req, " hits"}, v_hits, hits);
    @(negedge clk);
    chk({req, " R8 done one cycle"}, done, 0);
    chk({req, " R11 class held"}, v_class, cls);
    chk({req, " R11 hits held"}, v_hits, hits);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 ready in reset", in_ready, 0);
    chk("R1 class in reset", v_class, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 0);
    chk("R1 hits after reset", v_hits, 0);
  endtask

  task automatic t_clean;
    open_run("R2");
    for (int i = 0; i < 5; i++) same(i[0], i[1:0], 6'(i * 7));
    close_run(1, 0, 0, 0, "R7 R3 clean trace");
  endtask

  task automatic t_alu_fault;
    open_run("R2");
    div(0, 1, 3); same(1, 2, 4); div(1, 1, 9); div(0, 1, 12); same(0, 1, 20);
    close_run(1, 1, 1, 3, "R4 R5 alu fault");
  endtask

  task automatic t_field_mismatch;
    open_run("R2");
    send(7, 7, 0, 1, 0, 0, 40, 40);
    send(7, 7, 1, 1, 1, 2, 40, 40);
    send(7, 7, 0, 0, 2, 2, 40, 41);
    close_run(1, 3, 40, 3, "R3 R5 field mismatch");
  endtask

  task automatic t_cross_tie;
    open_run("R2");
    div(0, 2, 5); div(1, 0, 6);
    close_run(1, 1, 0, 1, "R6 cross-class tie");
  endtask

  task automatic t_alu_tie;
    open_run("R2");
    div(0, 3, 1); div(1, 1, 2); div(0, 3, 3); div(1, 1, 4);
    close_run(1, 1, 1, 2, "R6 in-class tie");
  endtask

  task automatic t_restart_clears;
    open_run("R2 restart");
    same(0, 0, 0);
    close_run(1, 0, 0, 0, "R2 counters cleared");
  endtask

  task automatic t_saturate;
    open_run("R2");
    for (int i = 0; i < 300; i++) div(1, 2, 6'(i));
    close_run(1, 1, 2, 255, "R10 saturation");
  endtask

  task automatic t_limit;
    open_run("R2");
    for (int i = 0; i < 1000; i++) div(i[0], 3, 6'(i));
    close_run(0, 1, 3, 255, "R9 limit cutoff");
    chk("R9 beats accepted", accepted, 1000);
    send(1, 2, 0, 0, 0, 0, 0, 0);
    chk("R9 extra beat refused", accepted, 1000);
    @(negedge clk); in_valid = 0;
    chk("R9 R11 verdict unchanged", v_hits, 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_clean;
    t_alu_fault;
    t_field_mismatch;
    t_cross_tie;
    t_alu_tie;
    t_restart_clears;
    t_saturate;
    t_limit;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule